// File: doc/BRIEF.md
# Image Sensor Frame Capture Engine

The block stores a single monochrome frame from a CMOS image sensor into an external asynchronous SRAM. The sensor provides an 8-bit pixel bus, a line-valid level and a frame-sync level. The block runs on the sensor's pixel clock. It brings both sync levels through two-flop synchronisers and delays the pixel bus by the same two stages, so each sample stays matched to its line-valid level. It then counts pixels and lines and drives the SRAM address bus, the data bus and an active-low write strobe.

Capture is one-shot. A host arm pulse moves the write pointer back to the base of the buffer. The block then waits for the next frame-sync edge and stores a fixed number of lines. When the last line is stored, it sets a done flag and pulses an interrupt so the host stops acquisition and services the buffer. The address of every line is fixed. A short line leaves the end of its slot unwritten, and a long line is cut off at the slot size. A frame sync that arrives in the middle of a frame aborts the capture and sets an error flag.

Top module: `img_capture`

## Requirements
- R1: While `rst_ni` is low, and until the first arm pulse after reset, `sram_we_no` is 1 and `done_o`, `err_o` and `irq_o` are 0.
- R2: No pixel is written unless the block is armed. After an arm pulse, nothing is written before the first rising edge of `vsync_i`. Line-valid pulses that come before that edge are ignored.
- R3: During capture, one pixel is written per clock cycle while `href_i` is high. `sram_data_o` carries the 8-bit sample, and consecutive writes within a line go to consecutive addresses.
- R4: Pixel p of line l (both counted from 0) is written to address BASE + l*PIX_PER_LINE + p. The highest address written in a frame is BASE + PIX_PER_LINE*LINES - 1.
- R5: If a line has fewer than PIX_PER_LINE pixels, the rest of its address slot is left unwritten. Pixels beyond PIX_PER_LINE in a line are dropped. In both cases the next line still starts at its fixed address.
- R6: When the falling edge of line number LINES is seen, `done_o` goes to 1 and `irq_o` is high for exactly one cycle. After that, frame syncs and lines cause no writes and no further interrupt until the next arm pulse.
- R7: A rising edge of `vsync_i` during capture aborts the frame. `err_o` goes to 1, `done_o` stays 0, no interrupt is raised, and nothing is written until the next arm pulse.
- R8: An arm pulse (`arm_i` high for one cycle) clears `done_o` and `err_o` and restarts the address sequence at BASE for the next frame. This applies in every state.
- R9: A write never targets an address outside BASE to BASE + PIX_PER_LINE*LINES - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sensor pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | PIX_W | Pixel sample from the sensor |
| href_i | input | 1 | Line-valid level from the sensor |
| vsync_i | input | 1 | Frame-sync level from the sensor |
| arm_i | input | 1 | Host arm pulse, one cycle |
| sram_addr_o | output | ADDR_W | SRAM write address |
| sram_data_o | output | PIX_W | SRAM write data |
| sram_we_no | output | 1 | SRAM write strobe, active low |
| done_o | output | 1 | Frame stored |
| irq_o | output | 1 | One-cycle completion request to the host |
| err_o | output | 1 | Frame aborted by an early frame sync |

## Verification
The bench uses 8-pixel lines and 4-line frames. It writes every stored pixel into a bench memory and compares each address of the buffer against a value computed from the line and pixel index. Any slip in the line-to-address mapping therefore shows up at every address after the slip.

It sends line pulses before the frame sync, so a block that starts capturing on arm alone is caught. A second frame after completion catches a block that keeps storing data or raises a second interrupt. Short and long lines catch a block that lets the address drift or writes past the slot. An early frame sync catches a block that marks the partial frame as done or keeps writing after the abort.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CAPT,
    ST_DONE
  } fc_state_e;
endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
  parameter int PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             href_i,
  input  logic             vsync_i,
  output logic [PIX_W-1:0] pix_q_o,
  output logic             href_q_o,
  output logic             href_rise_o,
  output logic             href_fall_o,
  output logic             vs_rise_o
);
  logic [1:0]       href_s, vs_s;
  logic             href_d, vs_d;
  logic [PIX_W-1:0] pix_d1, pix_d2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      href_s <= '0;
      vs_s   <= '0;
      href_d <= 1'b0;
      vs_d   <= 1'b0;
      pix_d1 <= '0;
      pix_d2 <= '0;
    end else begin
      href_s <= {href_s[0], href_i};
      vs_s   <= {vs_s[0], vsync_i};
      href_d <= href_s[1];
      vs_d   <= vs_s[1];
      pix_d1 <= pix_i;
      pix_d2 <= pix_d1;  // aligned with href_s[1]
    end
  end

  assign pix_q_o     = pix_d2;
  assign href_q_o    = href_s[1];
  assign href_rise_o = href_s[1] & ~href_d;
  assign href_fall_o = ~href_s[1] & href_d;
  assign vs_rise_o   = vs_s[1] & ~vs_d;
endmodule

// File: rtl/fc_frame_ctrl.sv
module fc_frame_ctrl
  import fc_pkg::*;
#(
  parameter int          PIX_PER_LINE = 640,
  parameter int          LINES        = 480,
  parameter int          ADDR_W       = 19,
  parameter logic [ADDR_W-1:0] BASE   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              vs_rise_i,
  input  logic              line_end_i,
  output logic              capt_ok_o,
  output logic [ADDR_W-1:0] line_base_o,
  output logic              done_o,
  output logic              irq_o,
  output logic              err_o
);
  localparam int LC_W = $clog2(LINES + 1);
  localparam logic [LC_W-1:0]   LAST_LINE = LC_W'(LINES - 1);
  localparam logic [ADDR_W-1:0] STRIDE    = ADDR_W'(PIX_PER_LINE);

  fc_state_e       state;
  logic [LC_W-1:0] line_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_IDLE;
      line_cnt    <= '0;
      line_base_o <= BASE;
      done_o      <= 1'b0;
      irq_o       <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (arm_i) begin
        state       <= ST_WAIT;
        line_cnt    <= '0;
        line_base_o <= BASE;
        done_o      <= 1'b0;
        err_o       <= 1'b0;
      end else begin
        unique case (state)
          ST_WAIT: if (vs_rise_i) state <= ST_CAPT;
          ST_CAPT: begin
            if (vs_rise_i) begin
              state <= ST_IDLE;
              err_o <= 1'b1;
            end else if (line_end_i) begin
              line_cnt    <= line_cnt + 1'b1;
              line_base_o <= line_base_o + STRIDE;
              if (line_cnt == LAST_LINE) begin
                state  <= ST_DONE;
                done_o <= 1'b1;
                irq_o  <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // no write in the cycle a capture is aborted or restarted
  assign capt_ok_o = (state == ST_CAPT) & ~vs_rise_i & ~arm_i;
endmodule

// File: rtl/fc_pix_wr.sv
module fc_pix_wr #(
  parameter int PIX_PER_LINE = 640,
  parameter int PIX_W        = 8,
  parameter int ADDR_W       = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capt_ok_i,
  input  logic [ADDR_W-1:0] line_base_i,
  input  logic [PIX_W-1:0]  pix_q_i,
  input  logic              href_q_i,
  input  logic              href_rise_i,
  input  logic              href_fall_i,
  output logic              line_end_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [PIX_W-1:0]  sram_data_o,
  output logic              sram_we_no
);
  localparam int PC_W = $clog2(PIX_PER_LINE + 1);
  localparam logic [PC_W-1:0] PPL = PC_W'(PIX_PER_LINE);

  logic            in_line;
  logic [PC_W-1:0] pix_cnt, idx;
  logic            take, wr;

  assign idx  = href_rise_i ? '0 : pix_cnt;
  assign take = capt_ok_i & href_q_i & (href_rise_i | in_line);
  assign wr   = take & (idx < PPL);  // long lines truncated here
  assign line_end_o = capt_ok_i & in_line & href_fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_line     <= 1'b0;
      pix_cnt     <= '0;
      sram_addr_o <= '0;
      sram_data_o <= '0;
      sram_we_no  <= 1'b1;
    end else begin
      sram_we_no <= ~wr;
      if (!capt_ok_i || href_fall_i) in_line <= 1'b0;
      else if (href_rise_i)          in_line <= 1'b1;
      if (wr) begin
        pix_cnt     <= idx + 1'b1;
        sram_addr_o <= line_base_i + ADDR_W'(idx);
        sram_data_o <= pix_q_i;
      end
    end
  end
endmodule

// File: rtl/img_capture.sv
module img_capture #(
  parameter int          PIX_PER_LINE = 640,
  parameter int          LINES        = 480,
  parameter int          PIX_W        = 8,
  parameter int          ADDR_W       = 19,
  parameter logic [ADDR_W-1:0] BASE   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              href_i,
  input  logic              vsync_i,
  input  logic              arm_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [PIX_W-1:0]  sram_data_o,
  output logic              sram_we_no,
  output logic              done_o,
  output logic              irq_o,
  output logic              err_o
);
  logic [PIX_W-1:0]  pix_q;
  logic              href_q, href_rise, href_fall, vs_rise;
  logic              capt_ok, line_end;
  logic [ADDR_W-1:0] line_base;

  fc_sync #(.PIX_W(PIX_W)) u_sync (
    .clk_i, .rst_ni, .pix_i, .href_i, .vsync_i,
    .pix_q_o(pix_q), .href_q_o(href_q), .href_rise_o(href_rise),
    .href_fall_o(href_fall), .vs_rise_o(vs_rise)
  );

  fc_frame_ctrl #(
    .PIX_PER_LINE(PIX_PER_LINE), .LINES(LINES), .ADDR_W(ADDR_W), .BASE(BASE)
  ) u_ctrl (
    .clk_i, .rst_ni, .arm_i,
    .vs_rise_i(vs_rise), .line_end_i(line_end),
    .capt_ok_o(capt_ok), .line_base_o(line_base),
    .done_o, .irq_o, .err_o
  );

  fc_pix_wr #(
    .PIX_PER_LINE(PIX_PER_LINE), .PIX_W(PIX_W), .ADDR_W(ADDR_W)
  ) u_wr (
    .clk_i, .rst_ni,
    .capt_ok_i(capt_ok), .line_base_i(line_base), .pix_q_i(pix_q),
    .href_q_i(href_q), .href_rise_i(href_rise), .href_fall_i(href_fall),
    .line_end_o(line_end),
    .sram_addr_o, .sram_data_o, .sram_we_no
  );
endmodule

// File: rtl/img_capture_chk.sv
module img_capture_chk #(
  parameter int          PIX_PER_LINE = 640,
  parameter int          LINES        = 480,
  parameter int          ADDR_W       = 19,
  parameter logic [ADDR_W-1:0] BASE   = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              arm_i,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_we_no,
  input logic              done_o,
  input logic              irq_o,
  input logic              err_o
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(PIX_PER_LINE * LINES);

  // R9
  addr_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (ADDR_W'(sram_addr_o - BASE) < SPAN));

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_no && $past(!sram_we_no)) |-> sram_addr_o == $past(sram_addr_o) + 1'b1);

  // R6
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> (!irq_o && done_o));

  // R6
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sram_we_no);

  // R7
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (sram_we_no && !done_o && !irq_o));

  // R8
  arm_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (!done_o && !err_o && sram_we_no));
endmodule

bind img_capture img_capture_chk #(
  .PIX_PER_LINE(PIX_PER_LINE), .LINES(LINES), .ADDR_W(ADDR_W), .BASE(BASE)
) u_chk (
  .clk_i, .rst_ni, .arm_i, .sram_addr_o, .sram_we_no, .done_o, .irq_o, .err_o
);

// File: tb/tb_img_capture.sv
module tb_img_capture;
  localparam int PPL    = 8;
  localparam int NL     = 4;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] BASE = 8'd16;
  localparam logic [7:0] SENT = 8'hEE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pix = '0;
  logic href = 1'b0, vs = 1'b0, arm = 1'b0;
  logic [ADDR_W-1:0] sram_addr;
  logic [7:0] sram_data;
  logic sram_we_n, done, irq, err;

  int checks = 0, errors = 0;
  int wr_cnt = 0, irq_cnt = 0, max_addr = 0;
  logic [7:0] mem [0:255];
  int line_len [0:NL-1];

  always #10 clk = ~clk;

  img_capture #(
    .PIX_PER_LINE(PPL), .LINES(NL), .PIX_W(8), .ADDR_W(ADDR_W), .BASE(BASE)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .pix_i(pix), .href_i(href), .vsync_i(vs),
    .arm_i(arm), .sram_addr_o(sram_addr), .sram_data_o(sram_data),
    .sram_we_no(sram_we_n), .done_o(done), .irq_o(irq), .err_o(err)
  );

  always @(negedge clk) begin
    if (rst_n && !sram_we_n) begin
      mem[sram_addr] = sram_data;
      wr_cnt++;
      if (int'(sram_addr) > max_addr) max_addr = int'(sram_addr);
    end
    if (rst_n && irq) irq_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pval(input int tag, input int l, input int p);
    return 8'((tag * 64) + (l * 12) + p + 1);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mem();
    for (int a = 0; a < 256; a++) mem[a] = SENT;
    max_addr = 0;
  endtask

  task automatic pulse_arm();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic send_vsync();
    vs = 1'b1;
    idle(3);
    vs = 1'b0;
    idle(3);
  endtask

  task automatic send_line(input int tag, input int l, input int n);
    for (int p = 0; p < n; p++) begin
      href = 1'b1;
      pix  = pval(tag, l, p);
      @(negedge clk);
    end
    href = 1'b0;
    pix  = 8'h00;
    idle(5);
  endtask

  task automatic send_frame(input int tag);
    send_vsync();
    for (int l = 0; l < NL; l++) send_line(tag, l, line_len[l]);
    idle(4);
  endtask

  task automatic check_buf(input string req, input int tag);
    for (int l = 0; l < NL; l++)
      for (int p = 0; p < PPL; p++)
        chk(req, int'(mem[int'(BASE) + l * PPL + p]),
            (p < line_len[l]) ? int'(pval(tag, l, p)) : int'(SENT));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w0, i0;
    clear_mem();
    for (int l = 0; l < NL; l++) line_len[l] = PPL;
    idle(3);
    // R1 during reset
    chk("R1 we_n in reset", int'(sram_we_n), 1);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 err in reset", int'(err), 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 irq after reset", int'(irq), 0);

    // R2: full frame while not armed
    send_frame(0);
    chk("R2 no writes unarmed", wr_cnt, 0);
    chk("R1 done unarmed", int'(done), 0);

    // R2: armed, lines before the frame sync
    pulse_arm();
    send_line(0, 0, PPL);
    send_line(0, 1, PPL);
    chk("R2 no writes before vsync", wr_cnt, 0);

    // R3 R4 R6: full frame
    send_frame(1);
    check_buf("R3 R4 pixel map", 1);
    chk("R3 write count", wr_cnt, PPL * NL);
    chk("R4 last address", max_addr, int'(BASE) + PPL * NL - 1);
    chk("R6 done set", int'(done), 1);
    chk("R6 single irq", irq_cnt, 1);
    chk("R6 err clear", int'(err), 0);

    // R6: later frames ignored
    w0 = wr_cnt;
    send_frame(2);
    chk("R6 no writes after done", wr_cnt, w0);
    chk("R6 done held", int'(done), 1);
    chk("R6 no second irq", irq_cnt, 1);

    // R8 R5: re-arm, short and long lines
    clear_mem();
    pulse_arm();
    idle(1);
    chk("R8 done cleared by arm", int'(done), 0);
    line_len[0] = PPL; line_len[1] = 5; line_len[2] = PPL + 3; line_len[3] = PPL;
    w0 = wr_cnt;
    send_frame(2);
    line_len[2] = PPL;  // truncated slot holds PPL pixels
    check_buf("R5 short/long line map", 2);
    chk("R5 write count", wr_cnt - w0, PPL + 5 + PPL + PPL);
    chk("R5 max address", max_addr, int'(BASE) + PPL * NL - 1);
    chk("R6 done after uneven frame", int'(done), 1);
    chk("R6 irq count", irq_cnt, 2);

    // R7: abort by early frame sync
    clear_mem();
    for (int l = 0; l < NL; l++) line_len[l] = PPL;
    pulse_arm();
    w0 = wr_cnt;
    i0 = irq_cnt;
    send_vsync();
    send_line(3, 0, PPL);
    send_line(3, 1, PPL);
    send_vsync();
    idle(2);
    chk("R7 partial writes", wr_cnt - w0, 2 * PPL);
    chk("R7 err set", int'(err), 1);
    chk("R7 done low", int'(done), 0);
    w0 = wr_cnt;
    send_line(3, 2, PPL);
    send_frame(3);
    chk("R7 no writes after abort", wr_cnt, w0);
    chk("R7 no irq", irq_cnt, i0);
    chk("R7 err held", int'(err), 1);

    // R8: arm clears error, restarts at BASE
    clear_mem();
    pulse_arm();
    idle(1);
    chk("R8 err cleared by arm", int'(err), 0);
    send_frame(1);
    check_buf("R8 restart at base", 1);
    chk("R8 done after restart", int'(done), 1);

    // R1: reset mid-state
    rst_n = 1'b0;
    idle(2);
    chk("R1 done cleared by reset", int'(done), 0);
    chk("R1 we_n high in reset", int'(sram_we_n), 1);
    rst_n = 1'b1;
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule